// File: doc/BRIEF.md
# Burst Mode Timeout Supervisor

This block supervises the burst mode of an embedded controller host interface. It sits beside the command engine and watches the pulses that report each accepted command byte. When the host asks for burst mode, the block raises a burst status flag. It also places an acknowledge byte into the output buffer and requests a system control interrupt (SCI). While the flag is up, the block counts 1 µs tick pulses against three limits: a window for the first access after entry, a shorter window for each later access, and a cap on the whole burst.

A burst can end in four ways: the host asks for the exit, a critical event arrives, the total cap runs out, or an access window runs out. The block reports every exit with a one-cycle pulse and a cause code. A host-requested exit raises no interrupt from this block, because the interrupt in that case comes from the input buffer draining. Every other exit raises an SCI request. All limits are parameters counted in tick pulses.

Top module: `burst_supervisor`

## Requirements
- R1: After synchronous reset, burst_active, obf_load, sci_req and exit_pulse are 0, obf_data is 0x00 and exit_cause is 0.
- R2: An accepted command byte 0x82 while idle sets burst_active one cycle later. In that same cycle obf_load and sci_req each pulse for one cycle and obf_data holds the acknowledge byte 0x90.
- R3: If no command is accepted after entry, the burst ends on the FIRST_TICKS-th tick. One cycle later burst_active is 0, exit_pulse is 1, exit_cause is 4 (access timeout) and sci_req is 1.
- R4: Every command accepted during a burst restarts the access window with a length of NEXT_TICKS ticks. If NEXT_TICKS ticks pass with no further command, the burst exits with cause 4 and an SCI request.
- R5: The burst ends on the TOTAL_TICKS-th tick counted from entry, whatever commands arrive. The exit carries cause 3 (total timeout) and an SCI request.
- R6: An accepted 0x83 during a burst clears burst_active one cycle later. It pulses exit_pulse with cause 1 (host exit) and leaves sci_req at 0.
- R7: A critical_req during a burst ends it with cause 2 (critical event) and an SCI request. While idle, critical_req has no effect.
- R8: An accepted 0x82 during a burst re-sends 0x90 with obf_load and sci_req. It counts as an access, and it does not restart the total timer.
- R9: When several exit reasons meet in one cycle, the order of precedence is 0x83, then critical_req, then total timeout, then access timeout. Any of these outranks a non-exit command in the same cycle.
- R10: While idle, accepted commands other than 0x82 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| cmd_valid | input | 1 | Command-accepted pulse from the command engine |
| cmd_byte | input | 8 | Command byte accepted with cmd_valid |
| critical_req | input | 1 | Request to leave burst mode for a critical event |
| burst_active | output | 1 | Burst status flag |
| obf_load | output | 1 | Pulse: load obf_data into the output buffer and set OBF |
| obf_data | output | 8 | Byte to load (0x90 acknowledge) |
| sci_req | output | 1 | Pulse: request an SCI |
| exit_pulse | output | 1 | Pulse: burst mode has just ended |
| exit_cause | output | 3 | Exit cause: 0 none, 1 host, 2 critical, 3 total, 4 access |

## Verification
The assertions hold on every cycle for these properties: each entry into burst comes with the 0x90 acknowledge and an SCI request; each fall of the flag comes with an exit pulse; a host exit never requests an SCI while every forced exit does; and a burst never lasts TOTAL_TICKS ticks. Only the bench scenarios can show the exact tick on which each window expires. The same holds for the restart of the access window by each command, for the re-acknowledge leaving the total timer untouched, and for the precedence between reasons that arrive together.

// File: rtl/burst_sup_pkg.sv
package burst_sup_pkg;

    localparam logic [7:0] CMD_BURST_ON  = 8'h82;
    localparam logic [7:0] CMD_BURST_OFF = 8'h83;
    localparam logic [7:0] BURST_ACK     = 8'h90;

    typedef enum logic [2:0] {
        EXIT_NONE     = 3'd0,
        EXIT_HOST     = 3'd1,
        EXIT_CRITICAL = 3'd2,
        EXIT_TOTAL    = 3'd3,
        EXIT_ACCESS   = 3'd4
    } exit_cause_e;

    typedef struct packed {
        logic burst_on;
        logic burst_off;
        logic other;
    } cmd_kind_t;

    function automatic cmd_kind_t classify_cmd(input logic valid, input logic [7:0] b);
        cmd_kind_t k;
        k.burst_on  = valid && (b == CMD_BURST_ON);
        k.burst_off = valid && (b == CMD_BURST_OFF);
        k.other     = valid && (b != CMD_BURST_ON) && (b != CMD_BURST_OFF);
        return k;
    endfunction

endpackage

// File: rtl/burst_window_timer.sv
module burst_window_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Fires on the tick that would bring the count up to the limit.
    assign expire = tick && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/burst_supervisor.sv
module burst_supervisor
    import burst_sup_pkg::*;
#(
    parameter int FIRST_TICKS = 400,
    parameter int NEXT_TICKS  = 50,
    parameter int TOTAL_TICKS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       critical_req,
    output logic       burst_active,
    output logic       obf_load,
    output logic [7:0] obf_data,
    output logic       sci_req,
    output logic       exit_pulse,
    output logic [2:0] exit_cause
);
    localparam int MAX_WIN = (FIRST_TICKS > NEXT_TICKS) ? FIRST_TICKS : NEXT_TICKS;
    localparam int MAX_ALL = (TOTAL_TICKS > MAX_WIN) ? TOTAL_TICKS : MAX_WIN;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);

    cmd_kind_t   kind;
    exit_cause_e exit_now;
    logic        enter, reack, access_touch;
    logic        first_phase;
    logic        total_exp, access_exp;
    logic [CNT_W-1:0] access_limit;

    assign kind         = classify_cmd(cmd_valid, cmd_byte);
    assign access_limit = first_phase ? CNT_W'(FIRST_TICKS) : CNT_W'(NEXT_TICKS);

    burst_window_timer #(.CNT_W(CNT_W)) u_total_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (!burst_active),
        .tick   (tick_us),
        .limit  (CNT_W'(TOTAL_TICKS)),
        .expire (total_exp)
    );

    burst_window_timer #(.CNT_W(CNT_W)) u_access_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (!burst_active || access_touch),
        .tick   (tick_us),
        .limit  (access_limit),
        .expire (access_exp)
    );

    // Exit reasons in precedence order; a non-exit command only counts if no exit fires.
    always_comb begin
        exit_now = EXIT_NONE;
        enter    = 1'b0;
        reack    = 1'b0;
        if (burst_active) begin
            if (kind.burst_off)     exit_now = EXIT_HOST;
            else if (critical_req)  exit_now = EXIT_CRITICAL;
            else if (total_exp)     exit_now = EXIT_TOTAL;
            else if (access_exp)    exit_now = EXIT_ACCESS;
            else if (kind.burst_on) reack    = 1'b1;
        end else if (kind.burst_on) begin
            enter = 1'b1;
        end
    end

    assign access_touch = burst_active && (exit_now == EXIT_NONE)
                        && (kind.burst_on || kind.other);

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_active <= 1'b0;
            first_phase  <= 1'b0;
            obf_load     <= 1'b0;
            obf_data     <= 8'h00;
            sci_req      <= 1'b0;
            exit_pulse   <= 1'b0;
            exit_cause   <= EXIT_NONE;
        end else begin
            if (enter)                       burst_active <= 1'b1;
            else if (exit_now != EXIT_NONE)  burst_active <= 1'b0;

            if (enter)             first_phase <= 1'b1;
            else if (access_touch) first_phase <= 1'b0;

            obf_load   <= enter || reack;
            obf_data   <= (enter || reack) ? BURST_ACK : 8'h00;
            sci_req    <= enter || reack
                       || ((exit_now != EXIT_NONE) && (exit_now != EXIT_HOST));
            exit_pulse <= (exit_now != EXIT_NONE);
            exit_cause <= exit_now;
        end
    end
endmodule

// File: rtl/burst_supervisor_chk.sv
module burst_supervisor_chk #(
    parameter int TOTAL_TICKS = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       tick_us,
    input logic       burst_active,
    input logic       obf_load,
    input logic [7:0] obf_data,
    input logic       sci_req,
    input logic       exit_pulse,
    input logic [2:0] exit_cause
);
    int unsigned ticks_in_burst;

    always_ff @(posedge clk) begin
        if (rst || !burst_active) ticks_in_burst <= 0;
        else if (tick_us)         ticks_in_burst <= ticks_in_burst + 1;
    end

    assert_entry_ack_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_active) |-> (obf_load && sci_req && obf_data == 8'h90));

    assert_ack_only_in_burst_R8: assert property (@(posedge clk) disable iff (rst)
        obf_load |-> burst_active);

    assert_host_exit_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (exit_pulse && exit_cause == 3'd1) |-> (!sci_req && !burst_active));

    assert_forced_exit_sci_R7: assert property (@(posedge clk) disable iff (rst)
        (exit_pulse && exit_cause != 3'd1) |-> sci_req);

    assert_fall_reported_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(burst_active) |-> exit_pulse);

    assert_exit_leaves_idle_R9: assert property (@(posedge clk) disable iff (rst)
        exit_pulse |-> (!burst_active && exit_cause != 3'd0));

    assert_total_bound_R5: assert property (@(posedge clk) disable iff (rst)
        burst_active |-> (ticks_in_burst < TOTAL_TICKS));
endmodule

bind burst_supervisor burst_supervisor_chk #(.TOTAL_TICKS(TOTAL_TICKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_us      (tick_us),
    .burst_active (burst_active),
    .obf_load     (obf_load),
    .obf_data     (obf_data),
    .sci_req      (sci_req),
    .exit_pulse   (exit_pulse),
    .exit_cause   (exit_cause)
);

// File: tb/test_burst_supervisor.sv
`timescale 1ns/1ps
module test_burst_supervisor;
    localparam int FIRST = 8;
    localparam int NEXT  = 4;
    localparam int TOTAL = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       critical_req = 1'b0;
    logic       burst_active, obf_load, sci_req, exit_pulse;
    logic [7:0] obf_data;
    logic [2:0] exit_cause;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    burst_supervisor #(.FIRST_TICKS(FIRST), .NEXT_TICKS(NEXT), .TOTAL_TICKS(TOTAL)) i_burst_supervisor (
        .clk(clk), .rst(rst), .tick_us(tick_us), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .critical_req(critical_req), .burst_active(burst_active), .obf_load(obf_load),
        .obf_data(obf_data), .sci_req(sci_req), .exit_pulse(exit_pulse), .exit_cause(exit_cause)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives one cycle of inputs starting at a falling edge; outputs are sampled at the next falling edge.
    task automatic step(input logic cv, input logic [7:0] b, input logic crit, input logic tk);
        cmd_valid = cv; cmd_byte = b; critical_req = crit; tick_us = tk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_byte = 8'h00; critical_req = 1'b0; tick_us = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic expect_exit(input string req, input int cause, input int sci);
        check(req, "burst_active", burst_active, 0);
        check(req, "exit_pulse", exit_pulse, 1);
        check(req, "exit_cause", exit_cause, cause);
        check(req, "sci_req", sci_req, sci);
    endtask

    task automatic enter_burst(input string req);
        step(1'b1, 8'h82, 1'b0, 1'b0);
        check(req, "burst_active", burst_active, 1);
        check(req, "obf_load", obf_load, 1);
        check(req, "obf_data", obf_data, 8'h90);
        check(req, "sci_req", sci_req, 1);
    endtask

    task automatic t_reset_R1;
        check("R1", "burst_active", burst_active, 0);
        check("R1", "obf_load", obf_load, 0);
        check("R1", "obf_data", obf_data, 0);
        check("R1", "sci_req", sci_req, 0);
        check("R1", "exit_pulse", exit_pulse, 0);
        check("R1", "exit_cause", exit_cause, 0);
    endtask

    task automatic t_idle_R10;
        step(1'b1, 8'h80, 1'b0, 1'b0);
        check("R10", "active after 0x80", burst_active, 0);
        check("R10", "obf_load after 0x80", obf_load, 0);
        step(1'b1, 8'h83, 1'b0, 1'b0);
        check("R10", "exit_pulse after 0x83", exit_pulse, 0);
        check("R10", "sci after 0x83", sci_req, 0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        check("R7", "idle critical exit_pulse", exit_pulse, 0);
        check("R7", "idle critical sci", sci_req, 0);
    endtask

    task automatic t_entry_R2;
        enter_burst("R2");
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R2", "obf_load one cycle", obf_load, 0);
        check("R2", "sci one cycle", sci_req, 0);
        check("R2", "still active", burst_active, 1);
        step(1'b1, 8'h83, 1'b0, 1'b0);
    endtask

    task automatic t_first_window_R3;
        enter_burst("R3");
        ticks(FIRST - 1);
        check("R3", "active before limit", burst_active, 1);
        ticks(1);
        expect_exit("R3", 4, 1);
    endtask

    task automatic t_per_access_R4;
        enter_burst("R4");
        ticks(3);
        step(1'b1, 8'h80, 1'b0, 1'b0);
        ticks(NEXT - 1);
        check("R4", "active inside window", burst_active, 1);
        step(1'b1, 8'h81, 1'b0, 1'b0);
        ticks(NEXT - 1);
        check("R4", "window restarted", burst_active, 1);
        ticks(1);
        expect_exit("R4", 4, 1);
    endtask

    task automatic t_total_R5;
        enter_burst("R5");
        for (int r = 0; r < 6; r++) begin
            ticks(3);
            step(1'b1, 8'h80, 1'b0, 1'b0);
        end
        ticks(1);
        check("R5", "active at 19 ticks", burst_active, 1);
        ticks(1);
        expect_exit("R5", 3, 1);
    endtask

    task automatic t_host_exit_R6;
        enter_burst("R6");
        ticks(2);
        step(1'b1, 8'h83, 1'b0, 1'b0);
        expect_exit("R6", 1, 0);
    endtask

    task automatic t_critical_R7;
        enter_burst("R7");
        ticks(1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        expect_exit("R7", 2, 1);
    endtask

    task automatic t_reack_R8;
        enter_burst("R8");
        ticks(3);
        step(1'b1, 8'h82, 1'b0, 1'b0);
        check("R8", "reack obf_load", obf_load, 1);
        check("R8", "reack data", obf_data, 8'h90);
        check("R8", "reack sci", sci_req, 1);
        check("R8", "reack active", burst_active, 1);
        for (int r = 0; r < 5; r++) begin
            ticks(3);
            step(1'b1, 8'h80, 1'b0, 1'b0);
        end
        ticks(1);
        check("R8", "active at 19 ticks", burst_active, 1);
        ticks(1);
        expect_exit("R8", 3, 1);
    endtask

    task automatic t_priority_R9;
        enter_burst("R9");
        step(1'b1, 8'h83, 1'b1, 1'b0);
        expect_exit("R9", 1, 0);
        enter_burst("R9");
        step(1'b1, 8'h80, 1'b1, 1'b0);
        expect_exit("R9", 2, 1);
        enter_burst("R9");
        ticks(FIRST - 1);
        step(1'b1, 8'h80, 1'b0, 1'b1);
        expect_exit("R9", 4, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_R1();
        t_idle_R10();
        t_entry_R2();
        t_first_window_R3();
        t_per_access_R4();
        t_total_R5();
        t_host_exit_R6();
        t_critical_R7();
        t_reack_R8();
        t_priority_R9();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule